// File: doc/BRIEF.md
# Dual-Rate Serial Channel

This block is one full-duplex asynchronous serial channel whose transmitter and receiver run at independent bit rates. Both rates come from a single 32-bit rate word. The low half carries the transmit divisor and the high half carries the receive divisor. Each divisor is programmed as the clock frequency divided by the wanted bit rate, minus one. A character enters through a single-entry holding register, is framed and shifted out on the serial output, and the receiver rebuilds incoming frames into a single-entry result register.

Control inputs cover several functions. They select parity and its sense, enable each direction on its own, and drive the request-to-send output. They also let software force a continuous break, gate the transmitter on clear-to-send or override that gate for test, and loop the transmitter back into the receiver. Separate status outputs, meant for an interrupt controller, report five conditions: a character waiting, a free holding register, a fully idle transmitter, an overrun and a framing error. A serial-reset input returns both engines to idle without touching the chip reset.

Top module: `twr_uart`

## Requirements
- R1: After reset `txd_o` is high, `rts_o` is low, `ev_tx_ready` and `ev_tx_empty` are high, and `ev_rx_ready`, `ev_overrun` and `ev_frame_err` are low.
- R2: The transmit divisor sits in `baud_cfg[14:0]`. Each transmitted bit lasts divisor+1 clocks. A frame is one low start bit, then 8 data bits with the least significant first, then an optional parity bit, then one high stop bit.
- R3: The receive divisor sits in `baud_cfg[30:16]`. The receiver samples each bit near the middle of a divisor+1 clock period, whatever the transmit divisor is.
- R4: With `ctl_par_en` high, a parity bit follows the data. If `ctl_par_even` is high, the data bits plus the parity bit hold an even number of ones; otherwise they hold an odd number. The receiver skips that bit.
- R5: A `tx_wr` pulse while `ev_tx_ready` is high loads the holding register, and `ev_tx_ready` drops one cycle later. A write while the register is full is ignored. `ev_tx_empty` is high only when the holding register is free and no frame is being shifted out.
- R6: While `ctl_tx_en` is low a held character is not sent and `txd_o` stays high.
- R7: With `ctl_break` high, a frame already under way finishes unchanged. After it, `txd_o` is held low until `ctl_break` falls.
- R8: With `ctl_loopback` high the transmitter feeds the receiver internally, and `txd_o` stays high.
- R9: A character that completes while `ev_rx_ready` is still high sets `ev_overrun` and is dropped. `rx_data` keeps the older character.
- R10: A stop bit sampled low sets `ev_frame_err` along with `ev_rx_ready`. The receiver rearms only after the line returns high. An `rx_rd` pulse clears `ev_rx_ready`, `ev_overrun` and `ev_frame_err`.
- R11: While `ctl_rx_en` is low no new frame is received.
- R12: A frame starts only while `cts_i` or `ctl_cts_force` is high.
- R13: A one-cycle pulse on `ctl_serial_reset` empties the holding register, clears all receive flags and leaves both engines idle.
- R14: `rts_o` follows `ctl_rts` with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_cfg | input | 32 | Rate word: [14:0] transmit divisor, [30:16] receive divisor |
| ctl_par_en | input | 1 | Add and expect a parity bit |
| ctl_par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| ctl_rts | input | 1 | Level for the request-to-send output |
| ctl_tx_en | input | 1 | Transmitter enable |
| ctl_rx_en | input | 1 | Receiver enable |
| ctl_break | input | 1 | Hold the serial output low after the current frame |
| ctl_loopback | input | 1 | Route the transmitter into the receiver |
| ctl_cts_force | input | 1 | Treat clear-to-send as asserted |
| ctl_serial_reset | input | 1 | Return both engines to idle |
| cts_i | input | 1 | Clear-to-send from the far end |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output |
| rts_o | output | 1 | Request-to-send output |
| tx_wr | input | 1 | Write pulse for the holding register |
| tx_data | input | 8 | Character to send |
| rx_rd | input | 1 | Read pulse that consumes the received character |
| rx_data | output | 8 | Last received character |
| ev_rx_ready | output | 1 | Received character waiting |
| ev_tx_ready | output | 1 | Holding register free |
| ev_tx_empty | output | 1 | Holding register free and shifter idle |
| ev_overrun | output | 1 | A character was lost to an unread one |
| ev_frame_err | output | 1 | Stop bit was sampled low |

## Verification
The checker assumes that the rate word is never changed while the transmitter is busy. It also assumes that `tx_wr` and `rx_rd` are single-cycle pulses and that `ctl_serial_reset` is pulsed rather than held. The bench follows all of this: it rewrites the rate word only when `ev_tx_empty` is high, and it drives every pulse for exactly one clock. Serial input is driven on falling clock edges at exactly divisor+1 clocks per bit, so the receiver's midpoint sampling always has several clocks of margin on either side. For the same reason, the bench's own mid-bit sampling of `txd_o` drifts past a bit boundary if a period is off by a single clock.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int unsigned TWR_DATA_W = 8;
  localparam int unsigned TWR_DIV_W  = 15;
  localparam int unsigned TWR_CFG_W  = 32;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/twr_bit_timer.sv
module twr_bit_timer #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  // Loading value N makes expired rise N cycles later, so the action on
  // expiry lands N+1 cycles after the load.
  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/twr_tx_engine.sv
module twr_tx_engine #(
  parameter int unsigned DATA_W = twr_pkg::TWR_DATA_W,
  parameter int unsigned DIV_W  = twr_pkg::TWR_DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              en,
  input  logic              cts_ok,
  input  logic              brk,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              line,
  output logic              hold_free,
  output logic              idle
);
  localparam int unsigned TAIL_W = DATA_W + 2;          // data, parity, stop
  localparam int unsigned LEFT_W = $clog2(TAIL_W + 1);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q;
  logic              busy_q;
  logic              line_q;
  logic [TAIL_W-1:0] tail_q;
  logic [LEFT_W-1:0] left_q;
  logic              tick;
  logic              launch;
  logic              t_load;
  logic              pbit;

  assign pbit   = par_even ? (^hold_q) : ~(^hold_q);
  assign launch = !busy_q && hold_full_q && en && cts_ok && !brk;
  assign t_load = launch || (busy_q && tick && (left_q != '0));

  twr_bit_timer #(.CNT_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (divisor),
    .expired  (tick)
  );

  always_ff @(posedge clk) begin
    if (wr && !hold_full_q) hold_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full_q <= 1'b0;
      busy_q      <= 1'b0;
      line_q      <= 1'b1;
      tail_q      <= '1;
      left_q      <= '0;
    end else begin
      if (wr && !hold_full_q) hold_full_q <= 1'b1;
      if (launch) begin
        hold_full_q <= 1'b0;
        busy_q      <= 1'b1;
        line_q      <= 1'b0;
        tail_q      <= {1'b1, (par_en ? pbit : 1'b1), hold_q};
        left_q      <= par_en ? LEFT_W'(DATA_W + 2) : LEFT_W'(DATA_W + 1);
      end else if (busy_q) begin
        if (tick) begin
          if (left_q == '0) begin
            busy_q <= 1'b0;
          end else begin
            line_q <= tail_q[0];
            tail_q <= {1'b1, tail_q[TAIL_W-1:1]};
            left_q <= left_q - 1'b1;
          end
        end
      end else begin
        line_q <= !brk;
      end
    end
  end

  assign line      = line_q;
  assign hold_free = !hold_full_q;
  assign idle      = !hold_full_q && !busy_q;
endmodule

// File: rtl/twr_rx_engine.sv
module twr_rx_engine
  import twr_pkg::*;
#(
  parameter int unsigned DATA_W = TWR_DATA_W,
  parameter int unsigned DIV_W  = TWR_DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              en,
  input  logic              par_en,
  input  logic              line_in,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              overrun,
  output logic              frame_err
);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic              bit_now;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] data_q;
  logic              ready_q;
  logic              ovr_q;
  logic              fe_q;
  logic              tick;
  logic              t_load;
  logic [DIV_W-1:0]  t_val;
  logic              finish;

  assign bit_now = sync_q[1];
  assign finish  = (state_q == RX_STOP) && tick;

  always_comb begin
    t_load = 1'b0;
    t_val  = divisor;
    case (state_q)
      RX_IDLE:  if (en && !bit_now) begin
                  t_load = 1'b1;
                  t_val  = divisor >> 1;
                end
      RX_START: if (tick && !bit_now) t_load = 1'b1;
      RX_DATA,
      RX_PAR:   if (tick) t_load = 1'b1;
      default:  t_load = 1'b0;
    endcase
  end

  twr_bit_timer #(.CNT_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (tick)
  );

  always_ff @(posedge clk) begin
    if (finish && !(ready_q && !rd)) data_q <= shift_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      state_q <= RX_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_in};
      case (state_q)
        RX_IDLE:  if (en && !bit_now) state_q <= RX_START;
        RX_START: if (tick) begin
                    idx_q   <= '0;
                    state_q <= bit_now ? RX_IDLE : RX_DATA;
                  end
        RX_DATA:  if (tick) begin
                    shift_q <= {bit_now, shift_q[DATA_W-1:1]};
                    idx_q   <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(DATA_W - 1))
                      state_q <= par_en ? RX_PAR : RX_STOP;
                  end
        RX_PAR:   if (tick) state_q <= RX_STOP;
        RX_STOP:  if (tick) state_q <= bit_now ? RX_IDLE : RX_HOLD;
        RX_HOLD:  if (bit_now) state_q <= RX_IDLE;
        default:  state_q <= RX_IDLE;
      endcase
      if (rd) begin
        ready_q <= 1'b0;
        ovr_q   <= 1'b0;
        fe_q    <= 1'b0;
      end
      if (finish) begin
        if (ready_q && !rd) ovr_q   <= 1'b1;
        else                ready_q <= 1'b1;
        if (!bit_now)       fe_q    <= 1'b1;
      end
    end
  end

  assign data      = data_q;
  assign ready     = ready_q;
  assign overrun   = ovr_q;
  assign frame_err = fe_q;
endmodule

// File: rtl/twr_uart.sv
module twr_uart
  import twr_pkg::*;
#(
  parameter int unsigned DATA_W = TWR_DATA_W,
  parameter int unsigned DIV_W  = TWR_DIV_W,
  parameter int unsigned CFG_W  = TWR_CFG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  baud_cfg,
  input  logic              ctl_par_en,
  input  logic              ctl_par_even,
  input  logic              ctl_rts,
  input  logic              ctl_tx_en,
  input  logic              ctl_rx_en,
  input  logic              ctl_break,
  input  logic              ctl_loopback,
  input  logic              ctl_cts_force,
  input  logic              ctl_serial_reset,
  input  logic              cts_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              rts_o,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              ev_rx_ready,
  output logic              ev_tx_ready,
  output logic              ev_tx_empty,
  output logic              ev_overrun,
  output logic              ev_frame_err
);
  localparam int unsigned RX_LSB = CFG_W / 2;

  logic             eng_rst;
  logic [DIV_W-1:0] tx_div;
  logic [DIV_W-1:0] rx_div;
  logic             tx_line;
  logic             rx_src;
  logic             rts_q;

  assign eng_rst = rst || ctl_serial_reset;
  assign tx_div  = baud_cfg[DIV_W-1:0];
  assign rx_div  = baud_cfg[RX_LSB +: DIV_W];
  assign rx_src  = ctl_loopback ? tx_line : rxd_i;

  twr_tx_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk       (clk),
    .rst       (eng_rst),
    .divisor   (tx_div),
    .en        (ctl_tx_en),
    .cts_ok    (cts_i || ctl_cts_force),
    .brk       (ctl_break),
    .par_en    (ctl_par_en),
    .par_even  (ctl_par_even),
    .wr        (tx_wr),
    .wr_data   (tx_data),
    .line      (tx_line),
    .hold_free (ev_tx_ready),
    .idle      (ev_tx_empty)
  );

  twr_rx_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
    .clk       (clk),
    .rst       (eng_rst),
    .divisor   (rx_div),
    .en        (ctl_rx_en),
    .par_en    (ctl_par_en),
    .line_in   (rx_src),
    .rd        (rx_rd),
    .data      (rx_data),
    .ready     (ev_rx_ready),
    .overrun   (ev_overrun),
    .frame_err (ev_frame_err)
  );

  always_ff @(posedge clk) begin
    if (rst) rts_q <= 1'b0;
    else     rts_q <= ctl_rts;
  end

  assign rts_o = rts_q;
  assign txd_o = ctl_loopback ? 1'b1 : tx_line;
endmodule

// File: rtl/twr_uart_checker.sv
module twr_uart_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CFG_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [CFG_W-1:0]  baud_cfg,
  input logic              ctl_break,
  input logic              ctl_loopback,
  input logic              ctl_serial_reset,
  input logic              txd_o,
  input logic              tx_wr,
  input logic              rx_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              ev_rx_ready,
  input logic              ev_tx_ready,
  input logic              ev_tx_empty,
  input logic              ev_overrun,
  input logic              ev_frame_err
);
  AST_RATE_STEADY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!ev_tx_empty && $past(!ev_tx_empty)) |-> $stable(baud_cfg)); // R2

  AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && ev_tx_ready && !ctl_serial_reset) |=> !ev_tx_ready); // R5

  AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl_break) && $past(ev_tx_empty) && !$past(ctl_serial_reset) &&
     !$past(rst) && !ctl_loopback) |-> !txd_o); // R7

  AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_overrun) |-> (ev_rx_ready && $past(ev_rx_ready))); // R9

  AST_OLD_CHAR_KEPT: assert property (@(posedge clk) disable iff (rst)
    ($past(ev_rx_ready) && !$past(rx_rd) && !$past(ctl_serial_reset)) |-> $stable(rx_data)); // R9

  AST_FRAME_ERR_WITH_CHAR: assert property (@(posedge clk) disable iff (rst)
    ev_frame_err |-> ev_rx_ready); // R10
endmodule

bind twr_uart twr_uart_checker #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_checker (
  .clk              (clk),
  .rst              (rst),
  .baud_cfg         (baud_cfg),
  .ctl_break        (ctl_break),
  .ctl_loopback     (ctl_loopback),
  .ctl_serial_reset (ctl_serial_reset),
  .txd_o            (txd_o),
  .tx_wr            (tx_wr),
  .rx_rd            (rx_rd),
  .rx_data          (rx_data),
  .ev_rx_ready      (ev_rx_ready),
  .ev_tx_ready      (ev_tx_ready),
  .ev_tx_empty      (ev_tx_empty),
  .ev_overrun       (ev_overrun),
  .ev_frame_err     (ev_frame_err)
);

// File: tb/twr_uart_bench.sv
module twr_uart_bench;
  localparam int TXD = 9;
  localparam int RXD = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] baud_cfg = '0;
  logic ctl_par_en = 0, ctl_par_even = 0, ctl_rts = 0, ctl_tx_en = 1, ctl_rx_en = 1;
  logic ctl_break = 0, ctl_loopback = 0, ctl_cts_force = 0, ctl_serial_reset = 0;
  logic cts_i = 1, rxd_i = 1, tx_wr = 0, rx_rd = 0;
  logic [7:0] tx_data = '0;
  logic txd_o, rts_o, ev_rx_ready, ev_tx_ready, ev_tx_empty, ev_overrun, ev_frame_err;
  logic [7:0] rx_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  twr_uart u_twr_uart (
    .clk(clk), .rst(rst), .baud_cfg(baud_cfg),
    .ctl_par_en(ctl_par_en), .ctl_par_even(ctl_par_even), .ctl_rts(ctl_rts),
    .ctl_tx_en(ctl_tx_en), .ctl_rx_en(ctl_rx_en), .ctl_break(ctl_break),
    .ctl_loopback(ctl_loopback), .ctl_cts_force(ctl_cts_force),
    .ctl_serial_reset(ctl_serial_reset), .cts_i(cts_i), .rxd_i(rxd_i),
    .txd_o(txd_o), .rts_o(rts_o), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .ev_rx_ready(ev_rx_ready),
    .ev_tx_ready(ev_tx_ready), .ev_tx_empty(ev_tx_empty),
    .ev_overrun(ev_overrun), .ev_frame_err(ev_frame_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run did not end", 1, 0);
    summary();
    $finish;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int txdiv, input int rxdiv);
    baud_cfg = {1'b0, 15'(rxdiv), 1'b0, 15'(txdiv)};
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    tx_wr = 1'b1; tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  // Capture one frame from txd_o at mid-bit points of a TXD+1 period.
  task automatic capture(input int nb, output logic [10:0] bits, output bit found);
    found = 1'b0;
    bits  = '1;
    for (int t = 0; t < 600 && !found; t++) begin
      @(negedge clk);
      if (txd_o == 1'b0) found = 1'b1;
    end
    if (found) begin
      repeat ((TXD + 1) / 2) @(negedge clk);
      bits[0] = txd_o;
      for (int k = 1; k < nb; k++) begin
        repeat (TXD + 1) @(negedge clk);
        bits[k] = txd_o;
      end
    end
  endtask

  task automatic check_tx_frame(input logic [7:0] d, input int pm, input string req);
    logic [10:0] bits;
    bit          found;
    int          nb;
    logic        pexp;
    nb   = (pm != 0) ? 11 : 10;
    pexp = (pm == 2) ? (^d) : ~(^d);
    capture(nb, bits, found);
    check(found, req, "frame start seen", int'(found), 1);
    check(bits[0] == 1'b0, req, "start bit", int'(bits[0]), 0);
    check(bits[8:1] == d, req, "data bits", int'(bits[8:1]), int'(d));
    if (pm != 0) check(bits[9] == pexp, req, "parity bit", int'(bits[9]), int'(pexp));
    check(bits[nb-1] == 1'b1, req, "stop bit", int'(bits[nb-1]), 1);
    repeat (TXD + 1) @(negedge clk);
    check(ev_tx_empty == 1'b1, req, "tx empty after frame", int'(ev_tx_empty), 1);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic stopv);
    @(negedge clk);
    rxd_i = 1'b0;
    repeat (RXD + 1) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxd_i = d[k];
      repeat (RXD + 1) @(negedge clk);
    end
    rxd_i = stopv;
    repeat (RXD + 1) @(negedge clk);
    rxd_i = 1'b1;
  endtask

  initial begin
    bit stay_high;
    set_cfg(TXD, RXD);
    cycles(5);
    rst = 1'b0;
    cycles(2);

    // R1 reset state
    check(txd_o == 1'b1, "R1", "txd idle", int'(txd_o), 1);
    check(rts_o == 1'b0, "R1", "rts", int'(rts_o), 0);
    check(ev_tx_ready == 1'b1, "R1", "tx ready", int'(ev_tx_ready), 1);
    check(ev_tx_empty == 1'b1, "R1", "tx empty", int'(ev_tx_empty), 1);
    check(ev_rx_ready == 1'b0, "R1", "rx ready", int'(ev_rx_ready), 0);
    check(ev_overrun == 1'b0, "R1", "overrun", int'(ev_overrun), 0);
    check(ev_frame_err == 1'b0, "R1", "frame err", int'(ev_frame_err), 0);

    // R14 rts follows after one clock
    ctl_rts = 1'b1;
    cycles(1);
    check(rts_o == 1'b1, "R14", "rts high", int'(rts_o), 1);
    ctl_rts = 1'b0;
    cycles(1);
    check(rts_o == 1'b0, "R14", "rts low", int'(rts_o), 0);

    // R2 frames without parity
    begin
      logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
      for (int i = 0; i < 5; i++) begin
        write_byte(pats[i]);
        check_tx_frame(pats[i], 0, "R2");
      end
    end

    // R4 odd (pm 1) and even (pm 2) parity
    for (int pm = 1; pm <= 2; pm++) begin
      logic [7:0] pp [3] = '{8'h01, 8'h7E, 8'hC3};
      ctl_par_en = 1'b1;
      ctl_par_even = (pm == 2);
      for (int i = 0; i < 3; i++) begin
        write_byte(pp[i]);
        check_tx_frame(pp[i], pm, "R4");
      end
    end
    ctl_par_en = 1'b0;
    ctl_par_even = 1'b0;

    // R5 / R6 holding register and transmit enable
    ctl_tx_en = 1'b0;
    write_byte(8'h5A);
    check(ev_tx_ready == 1'b0, "R5", "tx ready after write", int'(ev_tx_ready), 0);
    check(ev_tx_empty == 1'b0, "R5", "tx empty after write", int'(ev_tx_empty), 0);
    write_byte(8'h99);
    stay_high = 1'b1;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (!txd_o) stay_high = 1'b0;
    end
    check(stay_high, "R6", "line high while disabled", int'(stay_high), 1);
    ctl_tx_en = 1'b1;
    check_tx_frame(8'h5A, 0, "R5");
    stay_high = 1'b1;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (!txd_o || !ev_tx_empty) stay_high = 1'b0;
    end
    check(stay_high, "R5", "write while full dropped", int'(stay_high), 1);

    // R12 clear-to-send gating and forcing
    cts_i = 1'b0;
    write_byte(8'h42);
    stay_high = 1'b1;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (!txd_o) stay_high = 1'b0;
    end
    check(stay_high, "R12", "held without cts", int'(stay_high), 1);
    check(ev_tx_ready == 1'b0, "R12", "char still held", int'(ev_tx_ready), 0);
    ctl_cts_force = 1'b1;
    check_tx_frame(8'h42, 0, "R12");
    ctl_cts_force = 1'b0;
    cts_i = 1'b1;

    // R7 break set mid-frame
    write_byte(8'hE7);
    fork
      check_tx_frame(8'hE7, 0, "R7");
      begin
        cycles(30);
        ctl_break = 1'b1;
      end
    join
    begin
      bit stay_low = 1'b1;
      for (int t = 0; t < 100; t++) begin
        @(negedge clk);
        if (txd_o) stay_low = 1'b0;
      end
      check(stay_low, "R7", "line low in break", int'(stay_low), 1);
    end
    ctl_break = 1'b0;
    cycles(2);
    check(txd_o == 1'b1, "R7", "line high after break", int'(txd_o), 1);

    // R3 receive at its own divisor
    send_rx(8'hB4, 1'b1);
    cycles(2);
    check(ev_rx_ready == 1'b1, "R3", "rx ready", int'(ev_rx_ready), 1);
    check(rx_data == 8'hB4, "R3", "rx data", int'(rx_data), 8'hB4);
    check(ev_frame_err == 1'b0, "R3", "no frame err", int'(ev_frame_err), 0);
    read_rx();
    check(ev_rx_ready == 1'b0, "R10", "read clears ready", int'(ev_rx_ready), 0);

    // R9 overrun keeps the older character
    send_rx(8'h11, 1'b1);
    send_rx(8'h22, 1'b1);
    cycles(2);
    check(ev_overrun == 1'b1, "R9", "overrun set", int'(ev_overrun), 1);
    check(rx_data == 8'h11, "R9", "older char kept", int'(rx_data), 8'h11);
    check(ev_rx_ready == 1'b1, "R9", "ready still set", int'(ev_rx_ready), 1);
    read_rx();
    check(ev_overrun == 1'b0, "R10", "read clears overrun", int'(ev_overrun), 0);

    // R10 framing error and rearm
    send_rx(8'h6D, 1'b0);
    cycles(3);
    check(ev_frame_err == 1'b1, "R10", "frame err set", int'(ev_frame_err), 1);
    check(ev_rx_ready == 1'b1, "R10", "ready with frame err", int'(ev_rx_ready), 1);
    check(rx_data == 8'h6D, "R10", "data with frame err", int'(rx_data), 8'h6D);
    read_rx();
    check(ev_frame_err == 1'b0, "R10", "read clears frame err", int'(ev_frame_err), 0);
    send_rx(8'h0F, 1'b1);
    cycles(2);
    check(ev_rx_ready == 1'b1 && rx_data == 8'h0F, "R10", "rearmed receive",
          int'(rx_data), 8'h0F);
    read_rx();

    // R11 receiver disabled
    ctl_rx_en = 1'b0;
    send_rx(8'h33, 1'b1);
    cycles(5);
    check(ev_rx_ready == 1'b0, "R11", "no rx while disabled", int'(ev_rx_ready), 0);
    ctl_rx_en = 1'b1;
    cycles(5);

    // R13 serial reset
    send_rx(8'h44, 1'b1);
    cycles(2);
    ctl_tx_en = 1'b0;
    write_byte(8'h55);
    check(ev_tx_ready == 1'b0 && ev_rx_ready == 1'b1, "R13", "setup before reset",
          int'(ev_rx_ready), 1);
    @(negedge clk);
    ctl_serial_reset = 1'b1;
    @(negedge clk);
    ctl_serial_reset = 1'b0;
    check(ev_tx_ready == 1'b1, "R13", "hold freed", int'(ev_tx_ready), 1);
    check(ev_tx_empty == 1'b1, "R13", "tx empty", int'(ev_tx_empty), 1);
    check(ev_rx_ready == 1'b0, "R13", "rx ready cleared", int'(ev_rx_ready), 0);
    ctl_tx_en = 1'b1;
    stay_high = 1'b1;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (!txd_o) stay_high = 1'b0;
    end
    check(stay_high, "R13", "dropped char not sent", int'(stay_high), 1);

    // R8 loopback sweep over bytes and parity modes
    ctl_loopback = 1'b1;
    set_cfg(TXD, TXD);
    for (int pm = 0; pm < 3; pm++) begin
      ctl_par_en = (pm != 0);
      ctl_par_even = (pm == 2);
      for (int i = 0; i < 32; i++) begin
        logic [7:0] d;
        bit got;
        d = 8'(i * 37 + 5);
        write_byte(d);
        got = 1'b0;
        stay_high = 1'b1;
        for (int t = 0; t < 300 && !got; t++) begin
          @(negedge clk);
          if (!txd_o) stay_high = 1'b0;
          if (ev_rx_ready) got = 1'b1;
        end
        check(got && rx_data == d, "R8", "looped char", int'(rx_data), int'(d));
        check(stay_high, "R8", "pin idle in loopback", int'(stay_high), 1);
        read_rx();
      end
    end
    cycles(40);
    check(ev_rx_ready == 1'b0 && ev_frame_err == 1'b0, "R8", "loopback clean end",
          int'(ev_rx_ready), 0);

    summary();
    $finish;
  end
endmodule